// File: doc/BRIEF.md
# Ethernet Pause Transmit Flow Controller

This block sits on the transmit side of an Ethernet MAC and decides when the MAC should throttle its link partner. In full duplex it asks the frame generator for a Pause control frame carrying a configured pause time. After that frame, while the request stays in force, it counts slot-time ticks and asks for a refresh frame shortly before the advertised pause runs out. In half duplex the same configuration turns the block into a back-pressure source: it pulses a jam request each time a new receive frame begins, so the transmitter forces a collision.

Software programs the block with a single configuration write. The write carries a request bit, an enable bit, a 16-bit pause time and a 2-bit refresh-offset select. A busy output reads high from the accepted request until the frame generator reports the end of the Pause frame, and the block ignores configuration writes while busy is high. A slot time is 512 bit times (64 bytes). The slot tick input pulses once per slot.

Top module: `pause_flow_tx`

## Requirements
- R1: After reset `pauseSendReq`, `busy` and `jamReq` are low.
- R2: An accepted write (`cfgWrite` high while `busy` is low) with `cfgReq`=1, `cfgEnable`=1 and `fullDuplex`=1 raises `pauseSendReq` and `busy` on the next cycle, and `pauseSendTime` then equals the written pause time.
- R3: `pauseSendReq` and `busy` stay high until `pauseTxDone` is sampled. They are low in the cycle after that.
- R4: A configuration write while `busy` is high has no effect. `pauseSendTime` keeps its value, and no extra frame is requested after the current one completes.
- R5: In full duplex, a write with `cfgEnable`=0 requests no Pause frame, and `busy` stays low.
- R6: The refresh offset select chooses how many slot times the refresh is sent before the pause time ends: 0 → 4, 1 → 28, 2 → 144, 3 → 256. Counting slot ticks from `pauseTxDone`, the refresh request rises in the cycle after tick number (pause time − offset). For example, pause time 256 with select 1 fires on tick 228.
- R7: When the offset is greater than or equal to the pause time, the refresh request rises after the first slot tick.
- R8: Each completed refresh frame restarts the count, so refresh frames repeat at the same tick interval.
- R9: An accepted write with `cfgReq`=0 withdraws the request. No further refresh frame is requested, however many slot ticks follow.
- R10: In half duplex, with the stored enable and request bits both set, each `rxFrameStart` pulse produces a one-cycle `jamReq` in the following cycle.
- R11: `jamReq` stays low when `fullDuplex` is 1, or when the stored enable or request bit is 0.
- R12: In half duplex, a write with `cfgReq`=1 and `cfgEnable`=1 requests no Pause frame, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgReq | input | 1 | Request bit of the write (pause frame or back-pressure) |
| cfgEnable | input | 1 | Flow-control enable bit of the write |
| cfgPauseTime | input | 16 | Pause time in slot times |
| cfgThreshSel | input | 2 | Refresh offset select |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rxFrameStart | input | 1 | Pulse at the start of a received frame |
| slotTick | input | 1 | One pulse per slot time |
| pauseTxDone | input | 1 | Frame generator finished the Pause frame |
| pauseSendReq | output | 1 | Request to send a Pause frame |
| pauseSendTime | output | 16 | Pause time to place in the frame |
| jamReq | output | 1 | Request to send a jam |
| busy | output | 1 | Pause frame in progress; writes ignored |

## Verification
The hardest state to reach is the refresh point. The bench has to get a frame accepted and completed, then deliver exactly the right number of slot ticks, and at each tick it must know whether the refresh is due. The directed tasks first complete the initial frame through `pauseTxDone`. They then pulse `slotTick` one at a time and check that `pauseSendReq` stays low up to the tick before the computed threshold and rises on that tick. This is repeated for every offset select, for offsets at or above the pause time, and across consecutive refreshes.

// File: rtl/pft_pkg.sv
package pft_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } pftState_t;

  typedef struct packed {
    logic loadCfg;
    logic clearCnt;
    logic incCnt;
  } pftStrobe_t;

  localparam int OFFSET_W = 9;

  function automatic logic [OFFSET_W-1:0] offsetForSel(input logic [1:0] sel);
    case (sel)
      2'd0:    offsetForSel = 9'd4;
      2'd1:    offsetForSel = 9'd28;
      2'd2:    offsetForSel = 9'd144;
      default: offsetForSel = 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       cfgReq,
  input  logic       cfgEnable,
  input  logic       fullDuplex,
  input  logic       slotTick,
  input  logic       pauseTxDone,
  input  logic       refreshHit,
  output pftStrobe_t strobe,
  output logic       sendReq,
  output logic       busy
);

  pftState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (cfgWrite) begin
          strobe.loadCfg = 1'b1;
          if (cfgReq && cfgEnable && fullDuplex) stateNext = ST_SEND;
        end
      end
      ST_SEND: begin
        if (pauseTxDone) begin
          if (fullDuplex) begin
            stateNext       = ST_WAIT;
            strobe.clearCnt = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (!fullDuplex) begin
          stateNext = ST_IDLE;
        end else if (cfgWrite) begin
          strobe.loadCfg = 1'b1;
          stateNext      = (cfgReq && cfgEnable) ? ST_SEND : ST_IDLE;
        end else if (slotTick) begin
          if (refreshHit) stateNext     = ST_SEND;
          else            strobe.incCnt = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign sendReq = (state == ST_SEND);
  assign busy    = (state == ST_SEND);

endmodule

// File: rtl/pft_datapath.sv
module pft_datapath
  import pft_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pftStrobe_t        strobe,
  input  logic              cfgReq,
  input  logic              cfgEnable,
  input  logic [TIME_W-1:0] cfgPauseTime,
  input  logic [1:0]        cfgThreshSel,
  input  logic              fullDuplex,
  input  logic              rxFrameStart,
  output logic [TIME_W-1:0] pauseTime,
  output logic              refreshHit,
  output logic              jamReq
);

  localparam int CNT_W = TIME_W + 1;

  logic              reqReg;
  logic              enableReg;
  logic [1:0]        selReg;
  logic [CNT_W-1:0]  slotCnt;
  logic [CNT_W-1:0]  offsetExt;
  logic [CNT_W-1:0]  timeExt;
  logic [CNT_W-1:0]  threshold;
  logic              bpActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg    <= 1'b0;
      enableReg <= 1'b0;
      selReg    <= '0;
      pauseTime <= '0;
    end else if (strobe.loadCfg) begin
      reqReg    <= cfgReq;
      enableReg <= cfgEnable;
      selReg    <= cfgThreshSel;
      pauseTime <= cfgPauseTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                slotCnt <= '0;
    else if (strobe.clearCnt) slotCnt <= '0;
    else if (strobe.incCnt)   slotCnt <= slotCnt + 1'b1;
  end

  assign offsetExt  = CNT_W'(offsetForSel(selReg));
  assign timeExt    = CNT_W'(pauseTime);
  assign threshold  = (timeExt > offsetExt) ? (timeExt - offsetExt) : CNT_W'(1);
  assign refreshHit = ((slotCnt + 1'b1) >= threshold);

  assign bpActive = !fullDuplex && enableReg && reqReg;

  always_ff @(posedge clk) begin
    if (!rstN) jamReq <= 1'b0;
    else       jamReq <= bpActive && rxFrameStart;
  end

endmodule

// File: rtl/pause_flow_tx.sv
module pause_flow_tx
  import pft_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic        cfgReq,
  input  logic        cfgEnable,
  input  logic [15:0] cfgPauseTime,
  input  logic [1:0]  cfgThreshSel,
  input  logic        fullDuplex,
  input  logic        rxFrameStart,
  input  logic        slotTick,
  input  logic        pauseTxDone,
  output logic        pauseSendReq,
  output logic [15:0] pauseSendTime,
  output logic        jamReq,
  output logic        busy
);

  pftStrobe_t strobe;
  logic       refreshHit;

  pft_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .cfgReq     (cfgReq),
    .cfgEnable  (cfgEnable),
    .fullDuplex (fullDuplex),
    .slotTick   (slotTick),
    .pauseTxDone(pauseTxDone),
    .refreshHit (refreshHit),
    .strobe     (strobe),
    .sendReq    (pauseSendReq),
    .busy       (busy)
  );

  pft_datapath #(.TIME_W(16)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgReq      (cfgReq),
    .cfgEnable   (cfgEnable),
    .cfgPauseTime(cfgPauseTime),
    .cfgThreshSel(cfgThreshSel),
    .fullDuplex  (fullDuplex),
    .rxFrameStart(rxFrameStart),
    .pauseTime   (pauseSendTime),
    .refreshHit  (refreshHit),
    .jamReq      (jamReq)
  );

endmodule

// File: rtl/pft_checker.sv
module pft_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrite,
  input logic        cfgReq,
  input logic        cfgEnable,
  input logic [15:0] cfgPauseTime,
  input logic        fullDuplex,
  input logic        rxFrameStart,
  input logic        pauseTxDone,
  input logic        pauseSendReq,
  input logic [15:0] pauseSendTime,
  input logic        jamReq,
  input logic        busy
);

  AST_START_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !busy && cfgReq && cfgEnable && fullDuplex)
      |=> (pauseSendReq && busy && pauseSendTime == $past(cfgPauseTime))); // R2

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (pauseSendReq && !pauseTxDone) |=> (pauseSendReq && $stable(pauseSendTime))); // R3

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (pauseSendReq && pauseTxDone) |=> !pauseSendReq); // R3

  AST_TIME_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgWrite) |=> $stable(pauseSendTime)); // R4

  AST_NO_SEND_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !busy && !cfgEnable) |=> !pauseSendReq); // R5

  AST_JAM_HALF_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    jamReq |-> ($past(rxFrameStart) && !$past(fullDuplex))); // R11

endmodule

bind pause_flow_tx pft_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrite     (cfgWrite),
  .cfgReq       (cfgReq),
  .cfgEnable    (cfgEnable),
  .cfgPauseTime (cfgPauseTime),
  .fullDuplex   (fullDuplex),
  .rxFrameStart (rxFrameStart),
  .pauseTxDone  (pauseTxDone),
  .pauseSendReq (pauseSendReq),
  .pauseSendTime(pauseSendTime),
  .jamReq       (jamReq),
  .busy         (busy)
);

// File: tb/tb_pause_flow_tx.sv
module tb_pause_flow_tx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrite, cfgReq, cfgEnable;
  logic [15:0] cfgPauseTime;
  logic [1:0]  cfgThreshSel;
  logic        fullDuplex, rxFrameStart, slotTick, pauseTxDone;
  logic        pauseSendReq, jamReq, busy;
  logic [15:0] pauseSendTime;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pause_flow_tx dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgReq(cfgReq),
    .cfgEnable(cfgEnable), .cfgPauseTime(cfgPauseTime),
    .cfgThreshSel(cfgThreshSel), .fullDuplex(fullDuplex),
    .rxFrameStart(rxFrameStart), .slotTick(slotTick),
    .pauseTxDone(pauseTxDone), .pauseSendReq(pauseSendReq),
    .pauseSendTime(pauseSendTime), .jamReq(jamReq), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(input logic req, input logic en, input logic [15:0] pt,
                          input logic [1:0] sel);
    cfgWrite = 1'b1; cfgReq = req; cfgEnable = en; cfgPauseTime = pt; cfgThreshSel = sel;
    step();
    cfgWrite = 1'b0;
  endtask

  task automatic txDone();
    pauseTxDone = 1'b1;
    step();
    pauseTxDone = 1'b0;
  endtask

  task automatic tick();
    slotTick = 1'b1;
    step();
    slotTick = 1'b0;
  endtask

  function automatic int offsetOf(input int sel);
    case (sel)
      0: return 4;
      1: return 28;
      2: return 144;
      default: return 256;
    endcase
  endfunction

  // Counts ticks from the end of a frame; the send request must rise exactly on tick 'thr'.
  task automatic runToRefresh(input string req, input int thr);
    bit early = 0;
    for (int i = 1; i < thr; i++) begin
      tick();
      if (pauseSendReq) early = 1;
    end
    chk({req, " no early refresh"}, early, 0);
    tick();
    chk({req, " refresh on threshold tick"}, pauseSendReq, 1);
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWrite = 0; cfgReq = 0; cfgEnable = 0; cfgPauseTime = 0;
    cfgThreshSel = 0; fullDuplex = 1; rxFrameStart = 0; slotTick = 0; pauseTxDone = 0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 sendReq", pauseSendReq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 jamReq", jamReq, 0);
  endtask

  task automatic t_startAndRefresh();
    doReset();
    writeCfg(1, 1, 16'h0100, 2'd1);
    chk("R2 sendReq", pauseSendReq, 1);
    chk("R2 busy", busy, 1);
    chk("R2 time", pauseSendTime, 16'h0100);
    repeat (3) step();
    chk("R3 held", pauseSendReq, 1);
    writeCfg(1, 1, 16'h0055, 2'd0);
    chk("R4 time unchanged", pauseSendTime, 16'h0100);
    txDone();
    chk("R3 dropped", pauseSendReq, 0);
    chk("R3 busy dropped", busy, 0);
    runToRefresh("R6 sel1 pt256", 228);
    chk("R4 refresh time", pauseSendTime, 16'h0100);
    txDone();
    runToRefresh("R8 second refresh", 228);
    txDone();
    writeCfg(0, 1, 16'h0100, 2'd1);
    begin
      bit seen = 0;
      for (int i = 0; i < 300; i++) begin
        tick();
        if (pauseSendReq) seen = 1;
      end
      chk("R9 withdrawn", seen, 0);
    end
  endtask

  task automatic t_thresholds();
    for (int s = 0; s < 4; s++) begin
      doReset();
      writeCfg(1, 1, 16'd300, s[1:0]);
      txDone();
      runToRefresh($sformatf("R6 sel%0d pt300", s), 300 - offsetOf(s));
      txDone();
    end
  endtask

  task automatic t_largeOffset();
    doReset();
    writeCfg(1, 1, 16'd100, 2'd2);
    txDone();
    chk("R7 before tick", pauseSendReq, 0);
    tick();
    chk("R7 offset>pt first tick", pauseSendReq, 1);
    txDone();
    writeCfg(1, 1, 16'd256, 2'd3);
    txDone();
    tick();
    chk("R7 offset==pt first tick", pauseSendReq, 1);
    txDone();
  endtask

  task automatic t_disabled();
    doReset();
    writeCfg(1, 0, 16'h0040, 2'd0);
    chk("R5 no send", pauseSendReq, 0);
    chk("R5 busy low", busy, 0);
    repeat (5) tick();
    chk("R5 still no send", pauseSendReq, 0);
  endtask

  task automatic t_halfDuplex();
    doReset();
    fullDuplex = 0;
    writeCfg(1, 1, 16'h0040, 2'd0);
    chk("R12 no send", pauseSendReq, 0);
    chk("R12 busy low", busy, 0);
    rxFrameStart = 1; step(); rxFrameStart = 0;
    chk("R10 jam", jamReq, 1);
    step();
    chk("R10 jam one cycle", jamReq, 0);
    writeCfg(0, 1, 16'h0040, 2'd0);
    rxFrameStart = 1; step(); rxFrameStart = 0;
    chk("R11 req clear no jam", jamReq, 0);
    writeCfg(1, 0, 16'h0040, 2'd0);
    rxFrameStart = 1; step(); rxFrameStart = 0;
    chk("R11 enable clear no jam", jamReq, 0);
    writeCfg(1, 1, 16'h0040, 2'd0);
    fullDuplex = 1;
    rxFrameStart = 1; step(); rxFrameStart = 0;
    chk("R11 full duplex no jam", jamReq, 0);
    chk("R11 no pause from stored bits", pauseSendReq, 0);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  initial begin
    t_reset();
    t_startAndRefresh();
    t_thresholds();
    t_largeOffset();
    t_disabled();
    t_halfDuplex();
    finishRun();
  end

endmodule